// File: doc/BRIEF.md
# ATA Single-Sector Command Sequencer

This block drives one complete ATA PIO command on behalf of a user agent. The agent supplies a 28-bit logical block address, a drive select and an operation: identify, read one sector or write one sector. The sequencer then works through a word-wide task-file register port. It waits until the drive is no longer busy and loads the count, address and device registers. It then issues the command, waits for the drive to request data, and moves exactly 256 16-bit words. On a read or identify the words go out through a valid/ready stream. On a write they come in through one.

The register port carries one access at a time. The request stays asserted, with stable address, direction and write data, until the far side acknowledges it. Read data is taken in the acknowledge cycle. The operation ends with a one-cycle done pulse. If the drive flags an error, or a polling wait runs past its limit, the sequencer reads the error register and returns its low byte together with an error flag.

Top module: `ata_sector_seq`

## Requirements
- R1: Out of reset the block is idle: busy_o, done_o, err_o, rd_valid_o, wr_ready_o and reg_req_o are all 0, and none of them rises while idle until start_i is seen.
- R2: After a start, the first register accesses are reads of register 7 (status), repeated while status bit 7 (busy) is 1. The first read with bit 7 clear and bit 0 clear ends the wait.
- R3: The parameter writes then follow in this order: register 2 = 1, register 3 = lba[7:0], register 4 = lba[15:8], register 5 = lba[23:16], register 6 = {3'b111, drive, lba[27:24]}. The drive bit is 0 for master and 1 for slave. Each register takes its value in the low byte, with the high byte 0.
- R4: The next access writes register 7 with the command code: op 2'b00 (identify) gives 0xEC, op 2'b01 (read) gives 0x20 and op 2'b10 (write) gives 0x30.
- R5: After the command, status (register 7) is read until bit 7 is 0 and bit 3 (data request) is 1.
- R6: For identify and read, register 0 is read 256 times. Each word is presented on rd_data_o with rd_valid_o held, and the data unchanged, until rd_ready_i. Words leave in the order they were read.
- R7: For write, 256 words are accepted from wr_data_i on cycles where wr_valid_i and wr_ready_o are both high. Each word is written to register 0 in order, and the bus stays idle while a word is awaited.
- R8: After the last word, done_o pulses for exactly one cycle with err_o 0, busy_o falls, and no further register access occurs.
- R9: A status read with bit 7 = 0 and bit 0 = 1 in either wait ends the operation. Register 1 is read next, with no parameter or data access after the failing read. done_o pulses with err_o = 1 and err_code_o = that register's low byte.
- R10: If POLL_LIMIT consecutive status reads in one wait fail to meet its exit condition, register 1 is read, and the operation completes as in R9 with err_o = 1.
- R11: A register request keeps reg_addr_o, reg_we_o and reg_wdata_o constant until the cycle in which reg_ack_i is seen.
- R12: start_i is ignored while busy_o is 1. The running command completes unchanged, with a single command write and a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a command (sampled when idle) |
| op_i | input | 2 | Operation: 00 identify, 01 read, 10 write |
| lba_i | input | 28 | Logical block address |
| drive_i | input | 1 | Drive select: 0 master, 1 slave |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last command ended in error |
| err_code_o | output | 8 | Low byte of error register on failure |
| rd_data_o | output | 16 | Outgoing data word |
| rd_valid_o | output | 1 | rd_data_o valid |
| rd_ready_i | input | 1 | User accepts rd_data_o |
| wr_data_i | input | 16 | Incoming data word |
| wr_valid_i | input | 1 | wr_data_i valid |
| wr_ready_o | output | 1 | Sequencer accepts wr_data_i |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | Access is a write |
| reg_addr_o | output | 3 | Task-file register index |
| reg_wdata_o | output | 16 | Register write data |
| reg_ack_i | input | 1 | Access complete |
| reg_rdata_i | input | 16 | Register read data, valid with reg_ack_i |

## Verification
The command flow is exercised with each of the three operations. The runs vary the number of busy status reads in both waits, the drive bit and the address bytes, so that swapped address registers, a wrong device nibble or a wrong command code show up in the recorded access log. Reads run with and without rd_ready_i back-pressure, and writes with gaps in wr_valid_i. These runs separate correct word ordering and holding from lost or repeated words. Error-bit injection in each wait, and a status that never meets either exit condition, separate the error path from the timeout path and check the exact count of polls. A start pulse during a transfer checks that commands cannot be re-entered.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam int LBA_W = 28;

  typedef enum logic [1:0] {
    OP_IDENT = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } ata_op_e;

  localparam logic [2:0] RG_DATA  = 3'd0;
  localparam logic [2:0] RG_ERR   = 3'd1;
  localparam logic [2:0] RG_COUNT = 3'd2;
  localparam logic [2:0] RG_LBA0  = 3'd3;
  localparam logic [2:0] RG_LBA1  = 3'd4;
  localparam logic [2:0] RG_LBA2  = 3'd5;
  localparam logic [2:0] RG_DEV   = 3'd6;
  localparam logic [2:0] RG_CMDST = 3'd7;

  localparam int ST_BSY = 7;
  localparam int ST_DRQ = 3;
  localparam int ST_ERR = 0;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL_RDY, S_PARAM, S_POLL_DRQ,
    S_RD_REG, S_RD_OUT, S_WR_IN, S_WR_REG, S_ERR_RD
  } seq_state_e;

  function automatic logic [7:0] cmd_of(ata_op_e op);
    case (op)
      OP_READ:  return 8'h20;
      OP_WRITE: return 8'h30;
      default:  return 8'hEC;
    endcase
  endfunction
endpackage

// File: rtl/ata_param_mux.sv
module ata_param_mux
  import ata_seq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2:0]       step_i,
  input  ata_op_e          op_i,
  input  logic [LBA_W-1:0] lba_i,
  input  logic             drive_i,
  output logic [2:0]       addr_o,
  output logic [DW-1:0]    wdata_o,
  output logic             last_o
);
  logic [7:0] byte_w;

  always_comb begin
    addr_o = RG_CMDST;
    byte_w = cmd_of(op_i);
    case (step_i)
      3'd0: begin addr_o = RG_COUNT; byte_w = 8'd1;          end
      3'd1: begin addr_o = RG_LBA0;  byte_w = lba_i[7:0];    end
      3'd2: begin addr_o = RG_LBA1;  byte_w = lba_i[15:8];   end
      3'd3: begin addr_o = RG_LBA2;  byte_w = lba_i[23:16];  end
      3'd4: begin addr_o = RG_DEV;   byte_w = {3'b111, drive_i, lba_i[27:24]}; end
      default: ;
    endcase
  end

  assign wdata_o = {{(DW-8){1'b0}}, byte_w};
  assign last_o  = (step_i == 3'd5);
endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/ata_word_count.sv
module ata_word_count #(
  parameter int WORDS = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (WORDS > 2) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/ata_sector_seq.sv
module ata_sector_seq
  import ata_seq_pkg::*;
#(
  parameter int DW         = 16,
  parameter int WORDS      = 256,
  parameter int POLL_LIMIT = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [LBA_W-1:0] lba_i,
  input  logic             drive_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [7:0]       err_code_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic             reg_req_o,
  output logic             reg_we_o,
  output logic [2:0]       reg_addr_o,
  output logic [DW-1:0]    reg_wdata_o,
  input  logic             reg_ack_i,
  input  logic [DW-1:0]    reg_rdata_i
);
  seq_state_e       state_q;
  ata_op_e          op_q;
  logic [LBA_W-1:0] lba_q;
  logic             drive_q;
  logic [2:0]       step_q;
  logic [DW-1:0]    data_q;
  logic             done_q, err_q;
  logic [7:0]       err_code_q;

  logic [2:0]    pm_addr;
  logic [DW-1:0] pm_wdata;
  logic          pm_last;
  logic          tmr_last, tmr_tick, tmr_clear;
  logic          wc_last, wc_inc, wc_clear;
  logic          acc_done, st_bsy, st_drq, st_err, in_poll;

  ata_param_mux #(.DW(DW)) i_param_mux (
    .step_i  (step_q),
    .op_i    (op_q),
    .lba_i   (lba_q),
    .drive_i (drive_q),
    .addr_o  (pm_addr),
    .wdata_o (pm_wdata),
    .last_o  (pm_last)
  );

  ata_poll_timer #(.LIMIT(POLL_LIMIT)) i_poll_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tmr_clear),
    .tick_i  (tmr_tick),
    .last_o  (tmr_last)
  );

  ata_word_count #(.WORDS(WORDS)) i_word_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (wc_clear),
    .inc_i   (wc_inc),
    .last_o  (wc_last)
  );

  assign acc_done = reg_req_o && reg_ack_i;
  assign st_bsy   = reg_rdata_i[ST_BSY];
  assign st_drq   = !st_bsy && reg_rdata_i[ST_DRQ];
  assign st_err   = !st_bsy && reg_rdata_i[ST_ERR];
  assign in_poll  = (state_q == S_POLL_RDY) || (state_q == S_POLL_DRQ);

  // unsatisfied poll: busy, or (second wait) neither error nor data request
  assign tmr_tick  = acc_done && in_poll &&
                     (st_bsy || (state_q == S_POLL_DRQ && !st_err && !st_drq));
  assign tmr_clear = (state_q == S_IDLE) || (state_q == S_PARAM);
  assign wc_inc    = (state_q == S_RD_OUT && rd_ready_i) || (state_q == S_WR_REG && reg_ack_i);
  assign wc_clear  = (state_q == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      op_q       <= OP_IDENT;
      lba_q      <= '0;
      drive_q    <= 1'b0;
      step_q     <= '0;
      data_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      err_code_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          op_q       <= ata_op_e'(op_i);
          lba_q      <= lba_i;
          drive_q    <= drive_i;
          step_q     <= '0;
          err_q      <= 1'b0;
          err_code_q <= '0;
          state_q    <= S_POLL_RDY;
        end
        S_POLL_RDY: if (reg_ack_i) begin
          if (st_err)        state_q <= S_ERR_RD;
          else if (!st_bsy)  state_q <= S_PARAM;
          else if (tmr_last) state_q <= S_ERR_RD;
        end
        S_PARAM: if (reg_ack_i) begin
          if (pm_last) state_q <= S_POLL_DRQ;
          else         step_q  <= step_q + 3'd1;
        end
        S_POLL_DRQ: if (reg_ack_i) begin
          if (st_err)        state_q <= S_ERR_RD;
          else if (st_drq)   state_q <= (op_q == OP_WRITE) ? S_WR_IN : S_RD_REG;
          else if (tmr_last) state_q <= S_ERR_RD;
        end
        S_RD_REG: if (reg_ack_i) begin
          data_q  <= reg_rdata_i;
          state_q <= S_RD_OUT;
        end
        S_RD_OUT: if (rd_ready_i) begin
          if (wc_last) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_RD_REG;
          end
        end
        S_WR_IN: if (wr_valid_i) begin
          data_q  <= wr_data_i;
          state_q <= S_WR_REG;
        end
        S_WR_REG: if (reg_ack_i) begin
          if (wc_last) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_WR_IN;
          end
        end
        S_ERR_RD: if (reg_ack_i) begin
          err_code_q <= reg_rdata_i[7:0];
          err_q      <= 1'b1;
          done_q     <= 1'b1;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_req_o   = 1'b0;
    reg_we_o    = 1'b0;
    reg_addr_o  = RG_CMDST;
    reg_wdata_o = '0;
    case (state_q)
      S_POLL_RDY, S_POLL_DRQ: reg_req_o = 1'b1;
      S_PARAM: begin
        reg_req_o   = 1'b1;
        reg_we_o    = 1'b1;
        reg_addr_o  = pm_addr;
        reg_wdata_o = pm_wdata;
      end
      S_RD_REG: begin
        reg_req_o  = 1'b1;
        reg_addr_o = RG_DATA;
      end
      S_WR_REG: begin
        reg_req_o   = 1'b1;
        reg_we_o    = 1'b1;
        reg_addr_o  = RG_DATA;
        reg_wdata_o = data_q;
      end
      S_ERR_RD: begin
        reg_req_o  = 1'b1;
        reg_addr_o = RG_ERR;
      end
      default: ;
    endcase
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = err_code_q;
  assign rd_data_o  = data_q;
  assign rd_valid_o = (state_q == S_RD_OUT);
  assign wr_ready_o = (state_q == S_WR_IN);
endmodule

// File: rtl/ata_sector_seq_chk.sv
module ata_sector_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [DW-1:0] rd_data_o,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic          wr_ready_o,
  input logic          reg_req_o,
  input logic          reg_we_o,
  input logic [2:0]    reg_addr_o,
  input logic [DW-1:0] reg_wdata_o,
  input logic          reg_ack_i
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!reg_req_o && !rd_valid_o && !wr_ready_o));

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o) &&
                                   $stable(reg_we_o) && $stable(reg_wdata_o)));

  a_r6_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  a_r7_bus_idle_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ready_o |-> !reg_req_o);

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
endmodule

bind ata_sector_seq ata_sector_seq_chk #(.DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .rd_data_o   (rd_data_o),
  .rd_valid_o  (rd_valid_o),
  .rd_ready_i  (rd_ready_i),
  .wr_ready_o  (wr_ready_o),
  .reg_req_o   (reg_req_o),
  .reg_we_o    (reg_we_o),
  .reg_addr_o  (reg_addr_o),
  .reg_wdata_o (reg_wdata_o),
  .reg_ack_i   (reg_ack_i)
);

// File: tb/test_ata_sector_seq.sv
`timescale 1ns/1ps
module test_ata_sector_seq;
  localparam int DW = 16;
  localparam int WORDS = 256;
  localparam int PLIM = 16;
  localparam int ACC_LAT = 1;
  localparam int LOGN = 1024;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [27:0] lba_i = '0;
  logic drive_i = 1'b0;
  logic busy_o, done_o, err_o;
  logic [7:0] err_code_o;
  logic [DW-1:0] rd_data_o, wr_data_i, reg_wdata_o;
  logic rd_valid_o, wr_ready_o, reg_req_o, reg_we_o;
  logic rd_ready_i = 1'b0, wr_valid_i = 1'b0;
  logic [2:0] reg_addr_o;
  logic reg_ack_i = 1'b0;
  logic [DW-1:0] reg_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  ata_sector_seq #(.DW(DW), .WORDS(WORDS), .POLL_LIMIT(PLIM)) i_ata_sector_seq (.*);

  // configuration, written only by the test tasks
  int cfg_rdy_busy = 0, cfg_drq_busy = 0;
  bit cfg_err_rdy = 0, cfg_err_drq = 0, cfg_never_rdy = 0, cfg_never_drq = 0;
  bit cfg_bp = 0, cfg_wgap = 0;
  logic [15:0] cfg_err_val = 16'h0000;

  // drive model state
  int cyc = 0, wcnt = 0, rdy_left = 0, drq_left = 0, rptr = 0;
  bit cmd_seen = 0;
  int log_n = 0, rx_n = 0, tx_n = 0, done_cnt = 0, prot_err = 0;
  logic [19:0] log_q [LOGN];
  logic [15:0] rx_q [WORDS];
  logic [19:0] cap = '0;
  logic [19:0] exp_q [LOGN];
  int exp_n = 0;

  int n_vec = 0, n_bad = 0;

  function automatic logic [15:0] rpat(int i);
    return 16'(i * 37) ^ 16'hC3A5;
  endfunction
  function automatic logic [15:0] wpat(int i);
    return 16'(i * 91) ^ 16'h1E2D;
  endfunction

  assign wr_data_i = wpat(tx_n);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (start_i && !busy_o) begin
      reg_ack_i <= 1'b0;
      wcnt <= 0; rdy_left <= cfg_rdy_busy; drq_left <= 0; rptr <= 0;
      cmd_seen <= 0; log_n <= 0; rx_n <= 0; tx_n <= 0; done_cnt <= 0; prot_err <= 0;
    end else begin
      reg_ack_i <= 1'b0;
      if (done_o) done_cnt <= done_cnt + 1;
      if (rd_valid_o && rd_ready_i) begin
        rx_q[rx_n % WORDS] <= rd_data_o;
        rx_n <= rx_n + 1;
      end
      if (wr_valid_i && wr_ready_o) tx_n <= tx_n + 1;
      if (reg_req_o && !reg_ack_i) begin
        if (wcnt != 0 && {reg_we_o, reg_addr_o, reg_wdata_o} != cap) prot_err <= prot_err + 1;
        cap <= {reg_we_o, reg_addr_o, reg_wdata_o};
        if (wcnt == ACC_LAT) begin
          wcnt <= 0;
          reg_ack_i <= 1'b1;
          if (log_n < LOGN) log_q[log_n] <= {reg_we_o, reg_addr_o, reg_we_o ? reg_wdata_o : 16'h0};
          log_n <= log_n + 1;
          if (reg_we_o) begin
            if (reg_addr_o == 3'd7) begin cmd_seen <= 1; drq_left <= cfg_drq_busy; end
          end else begin
            case (reg_addr_o)
              3'd0: begin reg_rdata_i <= rpat(rptr); rptr <= rptr + 1; end
              3'd1: reg_rdata_i <= cfg_err_val;
              3'd7: begin
                if (!cmd_seen) begin
                  if (rdy_left > 0) begin rdy_left <= rdy_left - 1; reg_rdata_i <= 16'h0080; end
                  else if (cfg_err_rdy) reg_rdata_i <= 16'h0041;
                  else if (cfg_never_rdy) reg_rdata_i <= 16'h0080;
                  else reg_rdata_i <= 16'h0040;
                end else begin
                  if (drq_left > 0) begin drq_left <= drq_left - 1; reg_rdata_i <= 16'h0080; end
                  else if (cfg_err_drq) reg_rdata_i <= 16'h0041;
                  else if (cfg_never_drq) reg_rdata_i <= 16'h0040;
                  else reg_rdata_i <= 16'h0058;
                end
              end
              default: reg_rdata_i <= 16'h0000;
            endcase
          end
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    rd_ready_i <= !cfg_bp || (cyc % 3 == 0);
    wr_valid_i <= !cfg_wgap || (cyc % 4 != 1);
  end

  // global watchdog
  always @(posedge clk_i) if (cyc > 150000) begin
    n_vec++; n_bad++;
    $display("FAIL watchdog: run exceeded cycle budget act=%0d exp<=150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input bit we, input logic [2:0] a, input logic [15:0] d);
    exp_q[exp_n] = {we, a, d};
    exp_n++;
  endtask

  task automatic cmp_range(input int lo, input int hi, input string tag);
    int bad = -1;
    for (int i = lo; i < hi; i++)
      if (bad < 0 && (i >= log_n || log_q[i] !== exp_q[i])) bad = i;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, {tag, " log entry"}, (bad < log_n) ? 32'(log_q[bad]) : 32'hFFFFFFFF, 32'(exp_q[bad]));
  endtask

  task automatic launch(input logic [1:0] op, input logic [27:0] lba, input bit drv);
    @(negedge clk_i);
    op_i = op; lba_i = lba; drive_i = drv; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output bit e, output logic [7:0] code);
    int n = 0;
    while (!done_o && n < 20000) begin @(negedge clk_i); n++; end
    if (!done_o) chk(1'b0, "R8 done timeout", 0, 1);
    e = err_o; code = err_code_o;
    repeat (20) @(negedge clk_i);
  endtask

  // mode: 0 ok, 1 err first wait, 2 err second wait, 3 timeout first, 4 timeout second
  task automatic verify(input logic [1:0] op, input logic [27:0] lba, input bit drv, input int mode,
                        input bit e, input logic [7:0] code);
    int p0, p1, p2, p3;
    logic [7:0] cmd;
    cmd = (op == 2'b01) ? 8'h20 : (op == 2'b10) ? 8'h30 : 8'hEC;
    exp_n = 0;
    for (int i = 0; i < ((mode == 3) ? PLIM : cfg_rdy_busy + 1); i++) push(0, 3'd7, 0);
    p0 = exp_n;
    if (mode != 1 && mode != 3) begin
      push(1, 3'd2, 16'h0001);
      push(1, 3'd3, {8'h0, lba[7:0]});
      push(1, 3'd4, {8'h0, lba[15:8]});
      push(1, 3'd5, {8'h0, lba[23:16]});
      push(1, 3'd6, {8'h0, 3'b111, drv, lba[27:24]});
      push(1, 3'd7, {8'h0, cmd});
      p1 = exp_n;
      for (int i = 0; i < ((mode == 4) ? PLIM : cfg_drq_busy + 1); i++) push(0, 3'd7, 0);
      p2 = exp_n;
      if (mode == 0) for (int i = 0; i < WORDS; i++) push(op == 2'b10, 3'd0, (op == 2'b10) ? wpat(i) : 16'h0);
    end else begin
      p1 = p0; p2 = p0;
    end
    p3 = exp_n;
    if (mode != 0) push(0, 3'd1, 0);
    chk(log_n == exp_n, "R8 access count", log_n, exp_n);
    cmp_range(0, p0, (mode == 3) ? "R10 first-wait polls" : "R2 ready polling");
    if (p1 > p0) begin
      cmp_range(p0, p1 - 1, "R3 parameter writes");
      cmp_range(p1 - 1, p1, "R4 command code");
      cmp_range(p1, p2, (mode == 4) ? "R10 second-wait polls" : "R5 data-request polling");
    end
    if (mode == 0) begin
      cmp_range(p2, p3, (op == 2'b10) ? "R7 data writes" : "R6 data reads");
      chk(e == 1'b0, "R8 err_o clear", e, 0);
      chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
      if (op != 2'b10) begin
        int bad = -1;
        for (int i = 0; i < WORDS; i++) if (bad < 0 && rx_q[i] !== rpat(i)) bad = i;
        chk(rx_n == WORDS, "R6 words delivered", rx_n, WORDS);
        chk(bad < 0, "R6 word order/value", (bad < 0) ? 0 : 32'(rx_q[bad]), (bad < 0) ? 0 : 32'(rpat(bad)));
      end else begin
        chk(tx_n == WORDS, "R7 words accepted", tx_n, WORDS);
      end
    end else begin
      cmp_range(p3, p3 + 1, (mode >= 3) ? "R10 error register read" : "R9 error register read");
      chk(e == 1'b1, (mode >= 3) ? "R10 err_o" : "R9 err_o", e, 1);
      chk(code == cfg_err_val[7:0], "R9 err_code_o", code, cfg_err_val[7:0]);
      chk(rx_n == 0 && tx_n == 0, "R9 no data moved", rx_n + tx_n, 0);
    end
    chk(prot_err == 0, "R11 request held until ack", prot_err, 0);
  endtask

  task automatic set_cfg(input int rb, input int db, input bit er, input bit ed,
                         input bit nr, input bit nd, input bit bp, input bit wg, input logic [15:0] ev);
    cfg_rdy_busy = rb; cfg_drq_busy = db; cfg_err_rdy = er; cfg_err_drq = ed;
    cfg_never_rdy = nr; cfg_never_drq = nd; cfg_bp = bp; cfg_wgap = wg; cfg_err_val = ev;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !err_o, "R1 idle flags", {busy_o, done_o, err_o}, 0);
    chk(!reg_req_o && !rd_valid_o && !wr_ready_o, "R1 idle handshakes",
        {reg_req_o, rd_valid_o, wr_ready_o}, 0);
    repeat (10) @(negedge clk_i);
    chk(!busy_o && !reg_req_o, "R1 stays idle without start", {busy_o, reg_req_o}, 0);
  endtask

  task automatic t_identify;
    bit e; logic [7:0] c;
    set_cfg(3, 2, 0, 0, 0, 0, 0, 0, 16'h0);
    launch(2'b00, 28'h1234567, 1'b0);
    wait_done(e, c);
    verify(2'b00, 28'h1234567, 1'b0, 0, e, c);
  endtask

  task automatic t_read_bp;
    bit e; logic [7:0] c;
    set_cfg(0, 5, 0, 0, 0, 0, 1, 0, 16'h0);
    launch(2'b01, 28'hABCDEF1, 1'b1);
    wait_done(e, c);
    verify(2'b01, 28'hABCDEF1, 1'b1, 0, e, c);
  endtask

  task automatic t_write_gaps;
    bit e; logic [7:0] c;
    set_cfg(1, 0, 0, 0, 0, 0, 0, 1, 16'h0);
    launch(2'b10, 28'h0F00A5C, 1'b0);
    wait_done(e, c);
    verify(2'b10, 28'h0F00A5C, 1'b0, 0, e, c);
  endtask

  task automatic t_err_rdy;
    bit e; logic [7:0] c;
    set_cfg(2, 0, 1, 0, 0, 0, 0, 0, 16'hBE10);
    launch(2'b01, 28'h0000010, 1'b0);
    wait_done(e, c);
    verify(2'b01, 28'h0000010, 1'b0, 1, e, c);
  endtask

  task automatic t_err_drq;
    bit e; logic [7:0] c;
    set_cfg(0, 3, 0, 1, 0, 0, 0, 0, 16'h0004);
    launch(2'b10, 28'h7654321, 1'b1);
    wait_done(e, c);
    verify(2'b10, 28'h7654321, 1'b1, 2, e, c);
  endtask

  task automatic t_timeout_rdy;
    bit e; logic [7:0] c;
    set_cfg(0, 0, 0, 0, 1, 0, 0, 0, 16'h0080);
    launch(2'b00, 28'h0000001, 1'b0);
    wait_done(e, c);
    verify(2'b00, 28'h0000001, 1'b0, 3, e, c);
  endtask

  task automatic t_timeout_drq;
    bit e; logic [7:0] c;
    set_cfg(1, 2, 0, 0, 0, 1, 0, 0, 16'h0010);
    launch(2'b01, 28'hFFFFFFF, 1'b1);
    wait_done(e, c);
    verify(2'b01, 28'hFFFFFFF, 1'b1, 4, e, c);
  endtask

  task automatic t_start_while_busy;
    bit e; logic [7:0] c;
    int n = 0;
    set_cfg(0, 0, 0, 0, 0, 0, 1, 0, 16'h0);
    launch(2'b01, 28'h0345678, 1'b0);
    while (rx_n < 10 && n < 20000) begin @(negedge clk_i); n++; end
    op_i = 2'b10; lba_i = 28'h1111111; drive_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(e, c);
    verify(2'b01, 28'h0345678, 1'b0, 0, e, c);
    chk(!busy_o && !reg_req_o, "R12 idle after completion", {busy_o, reg_req_o}, 0);
    chk(done_cnt == 1, "R12 one done pulse", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    t_reset;
    t_identify;
    t_read_bp;
    t_write_gaps;
    t_err_rdy;
    t_err_drq;
    t_timeout_rdy;
    t_timeout_drq;
    t_start_while_busy;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule